// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices of unsigned integers, A and B, each N by N, on an N by N grid of multiply-accumulate cells that run in lock-step. A job starts with a single-cycle start pulse. The caller then presents N beats, one per cycle in which `in_valid` is high. Beat k carries column k of A and row k of B. The block registers each beat at its edges. It delays left-edge lane i by i extra cycles and top-edge lane j by j extra cycles. Operands then hop one cell per cycle: A values move rightward and B values move downward. Cell (i,j) therefore meets A[i][k] and B[k][j] in the same cycle and adds their product to its own accumulator.

When the caller is not presenting a beat, zeros enter the grid. After the last beat, zeros keep entering until the final pair has reached the far corner cell. The finished sums stay where they were built. The accumulators then form one shift chain per column that runs toward the bottom edge. One complete row of C = A·B leaves the bottom edge per cycle with `res_valid` high, bottom row first. A single-cycle `done` pulse follows the last row. A new job may start in the same cycle as that pulse.

Top module: `sys_matmul`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `res_valid` and `done` are low.
- R2: The result is the unsigned matrix product C = A·B. The first valid cycle carries row N-1 of C, the next carries row N-2, and so on down to row 0. Element C[r][j] sits at bits `[j*AW +: AW]` of `res_row`.
- R3: On each beat k (k = 0 to N-1, in order), bits `[i*DW +: DW]` of `a_col` hold A[i][k] and bits `[j*DW +: DW]` of `b_row` hold B[k][j]. Idle cycles with `in_valid` low between beats do not change the result.
- R4: `res_valid` first rises exactly 2N cycles after the cycle that carries the last beat. It then stays high for exactly N consecutive cycles.
- R5: `done` is high for exactly one cycle, the cycle immediately after the last valid result row, and never together with `res_valid`.
- R6: `in_valid` and the operand buses are ignored while no job is loading. Values presented before a start produce no output and do not enter the next result.
- R7: A start pulse that arrives while a job is loading, flushing or emitting results is ignored. The running job's result and timing are unchanged, and no second result set follows.
- R8: A start pulse in the same cycle as `done` is accepted. The new job's beats may begin in the next cycle, and its result is independent of the previous job.
- R9: The accumulator width AW = 2·DW + ceil(log2 N) holds the product of all-maximum operands without wrapping (260100 for N=4, DW=8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle job start; clears the accumulators |
| in_valid | input | 1 | Marks a cycle that carries one operand beat |
| a_col | input | N*DW | Column k of A; lane i feeds grid row i from the left |
| b_row | input | N*DW | Row k of B; lane j feeds grid column j from the top |
| res_valid | output | 1 | High while a result row is on `res_row` |
| res_row | output | N*AW | One row of C, bottom row first |
| done | output | 1 | One-cycle pulse after the last result row |

## Verification
Two of the block's actions can fall in the same cycle: the end-of-job `done` pulse and the acceptance of a new start. The bench watches for `done` and raises `start` in that same cycle. It then streams a second, different pair of matrices immediately. The collision is judged correct when both result sets match their independently computed products and each set keeps its own 2N-cycle latency and row count. A second collision places a start inside the flush window. That start must leave the running job's result and timing intact and produce no extra output.

// File: rtl/smm_pkg.sv
// Package: shared types and sizing helpers for the systolic matrix multiplier.
// Assumes: unsigned operands; accumulators sized so N full-scale products never wrap.
package smm_pkg;

    // Job sequencing phases of the controller.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_FLUSH = 3'd2,
        ST_DRAIN = 3'd3,
        ST_FIN   = 3'd4
    } smm_state_e;

    // Accumulator width: a DW x DW product needs 2*DW bits, and summing N of them
    // adds ceil(log2 N) bits.
    function automatic int acc_width(input int dw, input int n);
        return 2 * dw + $clog2(n);
    endfunction

endpackage

// File: rtl/smm_delay.sv
// Module: fixed-length register delay line, reset to zero.
// Used both for the per-lane edge skew and for the one-cell operand hops.
// Assumes: DEPTH >= 1; every stage shifts every cycle (no stall).
module smm_delay #(
    parameter int DW    = 8,
    parameter int DEPTH = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] stg [DEPTH];

    // Shift the chain by one stage per cycle; stage 0 takes the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                stg[k] <= '0;
            end
        end else begin
            stg[0] <= din;
            for (int k = 1; k < DEPTH; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign dout = stg[DEPTH-1];

endmodule

// File: rtl/smm_pe.sv
// Module: one output-stationary cell of the grid.
// Multiplies the operand arriving from the west by the one arriving from the north
// and adds the product into a local accumulator. During readout the accumulator
// instead loads the value of the cell above it, forming a shift chain toward the
// bottom edge.
// Assumes: clr, shift_en and acc_en are never high together (the controller
// guarantees it); priority is clr, then shift, then accumulate.
module smm_pe #(
    parameter int DW = 8,
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          acc_en,
    input  logic          shift_en,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    input  logic [AW-1:0] acc_up,
    output logic [AW-1:0] acc
);

    logic [AW-1:0] prod;

    // Unsigned product widened to the accumulator width.
    always_comb begin
        prod = AW'(a_in) * AW'(b_in);
    end

    // Accumulator update: clear on start, shift during readout, else accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (shift_en) begin
            acc <= acc_up;
        end else if (acc_en) begin
            acc <= acc + prod;
        end
    end

endmodule

// File: rtl/smm_ctrl.sv
// Module: job sequencer for the systolic multiplier.
// Phases: IDLE -> LOAD (N accepted beats) -> FLUSH (2N-1 zero cycles so the last
// beat reaches the far corner) -> DRAIN (N readout cycles) -> FIN (done pulse).
// Assumes: N >= 1. A start is honoured only in IDLE or FIN; elsewhere it is ignored.
module smm_ctrl
    import smm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    output logic take,
    output logic clr,
    output logic acc_en,
    output logic shift_en,
    output logic res_valid,
    output logic done
);

    localparam int CW = $clog2(2 * N);
    localparam logic [CW-1:0] LAST_BEAT  = CW'(N - 1);
    localparam logic [CW-1:0] LAST_FLUSH = CW'(2 * N - 2);
    localparam logic [CW-1:0] LAST_ROW   = CW'(N - 1);

    smm_state_e    state;
    logic [CW-1:0] cnt;
    logic          start_ok;

    // A start is only legal when no job occupies the grid.
    always_comb begin
        start_ok = start && ((state == ST_IDLE) || (state == ST_FIN));
    end

    // Phase register and shared phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start_ok) begin
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (in_valid) begin
                        if (cnt == LAST_BEAT) begin
                            state <= ST_FLUSH;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (cnt == LAST_FLUSH) begin
                        state <= ST_DRAIN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (cnt == LAST_ROW) begin
                        state <= ST_FIN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FIN: begin
                    cnt   <= '0;
                    state <= start_ok ? ST_LOAD : ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Phase decode into the grid's control strobes and the result flags.
    always_comb begin
        take      = (state == ST_LOAD) && in_valid;
        clr       = start_ok;
        acc_en    = (state == ST_LOAD) || (state == ST_FLUSH);
        shift_en  = (state == ST_DRAIN);
        res_valid = (state == ST_DRAIN);
        done      = (state == ST_FIN);
    end

endmodule

// File: rtl/sys_matmul.sv
// Module: top of the output-stationary systolic matrix multiplier.
// An N x N grid of smm_pe cells. Left-edge lane i is registered and delayed by
// i+1 cycles, and top-edge lane j by j+1 cycles. Operands then hop one cell per
// cycle east (A) and south (B), so cell (i,j) sees beat k in cycle k+i+j+1.
// Results shift out of the bottom row, one row per cycle.
// Assumes: unsigned operands; gated zeros enter whenever no beat is taken.
module sys_matmul
    import smm_pkg::*;
#(
    parameter  int N  = 4,
    parameter  int DW = 8,
    localparam int AW = acc_width(DW, N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            in_valid,
    input  logic [N*DW-1:0] a_col,
    input  logic [N*DW-1:0] b_row,
    output logic            res_valid,
    output logic [N*AW-1:0] res_row,
    output logic            done
);

    logic take, clr, acc_en, shift_en;

    logic [DW-1:0] a_edge [N];
    logic [DW-1:0] b_edge [N];
    logic [DW-1:0] a_h    [N][N];
    logic [DW-1:0] b_v    [N][N];
    logic [AW-1:0] acc_w  [N][N];

    smm_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .take      (take),
        .clr       (clr),
        .acc_en    (acc_en),
        .shift_en  (shift_en),
        .res_valid (res_valid),
        .done      (done)
    );

    for (genvar l = 0; l < N; l++) begin : g_edge
        // Zero padding: a lane carries data only when a beat is taken.
        always_comb begin
            a_edge[l] = take ? a_col[l*DW +: DW] : '0;
            b_edge[l] = take ? b_row[l*DW +: DW] : '0;
        end

        smm_delay #(.DW(DW), .DEPTH(l + 1)) u_skew_a (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (a_edge[l]),
            .dout  (a_h[l][0])
        );

        smm_delay #(.DW(DW), .DEPTH(l + 1)) u_skew_b (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (b_edge[l]),
            .dout  (b_v[0][l])
        );
    end

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            logic [AW-1:0] up;

            if (j < N - 1) begin : g_east
                smm_delay #(.DW(DW), .DEPTH(1)) u_hop_a (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .din   (a_h[i][j]),
                    .dout  (a_h[i][j+1])
                );
            end

            if (i < N - 1) begin : g_south
                smm_delay #(.DW(DW), .DEPTH(1)) u_hop_b (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .din   (b_v[i][j]),
                    .dout  (b_v[i+1][j])
                );
            end

            if (i == 0) begin : g_top
                assign up = '0;
            end else begin : g_inner
                assign up = acc_w[i-1][j];
            end

            smm_pe #(.DW(DW), .AW(AW)) u_pe (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr      (clr),
                .acc_en   (acc_en),
                .shift_en (shift_en),
                .a_in     (a_h[i][j]),
                .b_in     (b_v[i][j]),
                .acc_up   (up),
                .acc      (acc_w[i][j])
            );
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        assign res_row[j*AW +: AW] = acc_w[N-1][j];
    end

endmodule

// File: rtl/sys_matmul_chk.sv
// Module: protocol checker for sys_matmul's result interface, bound to the top.
// Tracks the length of each result burst with a counter instead of deep $past.
module sys_matmul_chk #(
    parameter int N = 4
) (
    input logic clk,
    input logic rst_n,
    input logic res_valid,
    input logic done
);

    logic [$clog2(N+1):0] run_len;

    // Count consecutive result cycles; restart on any gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (res_valid) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!res_valid && !done)); // R1
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (int'(run_len) < N)); // R4
    AST_BURST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(run_len) == N)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !res_valid); // R5

endmodule

bind sys_matmul sys_matmul_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .done      (done)
);

// File: tb/sys_matmul_test.sv
`timescale 1ns/1ps
module sys_matmul_test;

    localparam int N  = 4;
    localparam int DW = 8;
    localparam int AW = 2 * DW + $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            in_valid = 1'b0;
    logic [N*DW-1:0] a_col = '0;
    logic [N*DW-1:0] b_row = '0;
    logic            res_valid;
    logic [N*AW-1:0] res_row;
    logic            done;

    always #2.5 clk = ~clk;

    sys_matmul #(.N(N), .DW(DW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .a_col     (a_col),
        .b_row     (b_row),
        .res_valid (res_valid),
        .res_row   (res_row),
        .done      (done)
    );

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled away from the active edge.
    logic [N*AW-1:0] rows [16];
    int  vstart [4];
    int  dstamp [4];
    int  nrows = 0, nvs = 0, nds = 0;
    logic prev_v = 1'b0;

    always @(negedge clk) begin
        if (res_valid) begin
            if (!prev_v && nvs < 4) begin
                vstart[nvs] = cyc;
                nvs++;
            end
            if (nrows < 16) rows[nrows] = res_row;
            nrows++;
        end
        if (done && nds < 4) begin
            dstamp[nds] = cyc;
            nds++;
        end
        prev_v = res_valid;
    end

    int ma [N][N];
    int mb [N][N];
    int last_beat;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nrows = 0;
        nvs   = 0;
        nds   = 0;
    endtask

    task automatic kick();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Drive N beats; bit k of gap_mask inserts one idle cycle before beat k.
    task automatic feed(input int gap_mask);
        for (int k = 0; k < N; k++) begin
            if (gap_mask[k]) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            for (int l = 0; l < N; l++) begin
                a_col[l*DW +: DW] = DW'(ma[l][k]);
                b_row[l*DW +: DW] = DW'(mb[k][l]);
            end
            in_valid  = 1'b1;
            last_beat = cyc;
            @(negedge clk);
        end
        in_valid = 1'b0;
        a_col    = '0;
        b_row    = '0;
    endtask

    task automatic wait_done(input int count);
        while (nds < count) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [N*AW-1:0] exp_row(input int r);
        logic [N*AW-1:0] v;
        v = '0;
        for (int j = 0; j < N; j++) begin
            int s;
            s = 0;
            for (int k = 0; k < N; k++) s += ma[r][k] * mb[k][j];
            v[j*AW +: AW] = AW'(s);
        end
        return v;
    endfunction

    // R2: rows leave bottom-first.
    task automatic check_rows(input int base, input string req);
        for (int r = 0; r < N; r++) begin
            chk(rows[base + r] == exp_row(N - 1 - r), req, rows[base + r], exp_row(N - 1 - r));
        end
    endtask

    // R4 latency and R5 done placement.
    task automatic check_timing(input int idx, input int lb);
        chk(vstart[idx] == lb + 2 * N, "R4 first row latency", vstart[idx], lb + 2 * N);
        chk(dstamp[idx] == vstart[idx] + N, "R5 done after last row", dstamp[idx], vstart[idx] + N);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 res_valid low in reset", res_valid, 0);
        chk(done == 1'b0, "R1 done low in reset", done, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 res_valid low after reset", res_valid, 0);
        chk(done == 1'b0, "R1 done low after reset", done, 0);
    endtask

    task automatic t_plain();
        clear_mon();
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                ma[i][k] = i * N + k + 1;
                mb[i][k] = (i == k) ? 1 : 0;
            end
        kick();
        feed(0);
        wait_done(1);
        check_rows(0, "R2 identity product");
        chk(nrows == N, "R4 row count", nrows, N);
        check_timing(0, last_beat);
    endtask

    task automatic t_gaps();
        clear_mon();
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                ma[i][k] = (3 * i + 5 * k + 2) % 256;
                mb[i][k] = ((i + 2 * k + 1) * 7) % 256;
            end
        kick();
        feed(32'b1010);
        wait_done(1);
        check_rows(0, "R3 beats with idle gaps");
        chk(nrows == N, "R3 row count with gaps", nrows, N);
        check_timing(0, last_beat);
    endtask

    task automatic t_max();
        clear_mon();
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                ma[i][k] = 255;
                mb[i][k] = 255;
            end
        kick();
        feed(0);
        wait_done(1);
        check_rows(0, "R9 full-scale product");
        chk(rows[0][0 +: AW] == AW'(260100), "R9 no wrap", rows[0][0 +: AW], 260100);
    endtask

    task automatic t_ignore();
        clear_mon();
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            a_col    = '1;
            b_row    = '1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        a_col    = '0;
        b_row    = '0;
        repeat (2 * N + 2) @(negedge clk);
        chk(nrows == 0 && nds == 0, "R6 idle beats produce no output", nrows + nds, 0);
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                ma[i][k] = i + k;
                mb[i][k] = i * k + 1;
            end
        kick();
        feed(0);
        wait_done(1);
        check_rows(0, "R6 idle beats not accumulated");
    endtask

    task automatic t_busy();
        clear_mon();
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                ma[i][k] = (i + 1) * (k + 3);
                mb[i][k] = 11 + i - k;
            end
        kick();
        feed(0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(1);
        check_rows(0, "R7 start during flush ignored");
        check_timing(0, last_beat);
        repeat (4 * N) @(negedge clk);
        chk(nrows == N && nds == 1, "R7 no second result set", nrows * 10 + nds, N * 10 + 1);
    endtask

    task automatic t_b2b();
        int lb1;
        clear_mon();
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                ma[i][k] = (i + 1) * (k + 2);
                mb[i][k] = 9 - i - k + N;
            end
        kick();
        feed(0);
        lb1 = last_beat;
        while (!done) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_rows(0, "R8 first job before overlap");
        check_timing(0, lb1);
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                ma[i][k] = (7 * i + k) % 13;
                mb[i][k] = (i * i + 2 * k) % 17;
            end
        feed(32'b0100);
        wait_done(2);
        check_rows(N, "R8 job started on done cycle");
        chk(nrows == 2 * N, "R8 both result sets", nrows, 2 * N);
        check_timing(1, last_beat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_plain();
        t_gaps();
        t_max();
        t_ignore();
        t_busy();
        t_b2b();
        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule